// File: doc/BRIEF.md
# Batched Core Wake and Power-Mode Sequencer

This controller lives outside a duty-cycled processor core and keeps that core powered off while sensor samples arrive. Each incoming sample is written into a slotted second-level buffer. The buffer is split into `NUM_SLOTS` slots, and each slot holds one batch of `BATCH_LEN` samples. The core is woken only when a whole batch is ready. This trades a fixed latency of one batch for far fewer boot and state-transfer events.

To wake the core, the sequencer takes these steps in order:
1. Close the power switch.
2. Wait a programmable settle time.
3. Ask the external transfer engine to restore the filtering part of the core state.
4. Once the restore is acknowledged, open the single top-level clock gate.

When the core reports that it has finished a batch, the same steps run in reverse: gate the clock, save the state, settle, and open the power switch. If another batch finished while the core was running, the sequencer hands that batch straight to the core instead of powering down. While the core runs, it may ask for the decision-making code segment to be loaded on demand. If every buffer slot holds a batch that has not yet been consumed, further samples are dropped and a sticky error is raised.

Top module: `batch_wake_seq`

## Requirements
- R1: After reset, `pwr_en`, `clk_en`, `xfer_req`, `buf_we` and `ovf_err` are all 0, `mode` is sleep (0), and no batch is counted.
- R2: Each accepted sample appears on the buffer write port one cycle after its strobe. The write has `buf_we`=1, `buf_wdata` equal to the sample, and `buf_addr` = slot*`BATCH_LEN` + index. The index counts 0..`BATCH_LEN`-1 within the slot, and the slot advances cyclically after the last index.
- R3: The core stays powered off until a batch is complete. After `BATCH_LEN`-1 samples `pwr_en` is still 0. `pwr_en` rises within three cycles of the sample that completes the batch.
- R4: Power-up runs in this order: `pwr_en` is high for `settle_cyc`+1 cycles with `clk_en` low and no request. Then `xfer_req` rises with `xfer_op`=0 (restore filter segment). `clk_en` rises in the cycle after `xfer_ack`. `clk_en` is never high while `pwr_en` is low.
- R5: While the core is active, a pulse on `dec_req` issues a transfer with `xfer_op`=1 (load decision segment). The clock stays enabled during that transfer, and the core returns to active after the acknowledge.
- R6: When `core_done` arrives with no further batch waiting, `clk_en` drops in the next cycle and a save is requested with `xfer_op`=2 while power stays on. After the acknowledge, `pwr_en` stays high for `settle_cyc`+1 more cycles and then falls, leaving `mode` at sleep.
- R7: When `core_done` arrives while another completed batch is waiting, the core is not powered down. `mode` goes to idle (1) for one cycle with the clock still running and then back to active (2). `run_slot` advances to the next slot.
- R8: A sample that arrives while all slots hold unconsumed batches is not written (`buf_we` stays 0). It sets `ovf_err`, which stays set until reset.
- R9: `mode` reads 2 (active) while the clock is enabled and work is running, 1 (idle) while the clock is enabled with no work, and 0 (sleep) whenever the clock is gated.
- R10: Once raised, `xfer_req` stays high with a constant `xfer_op` until `xfer_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | DATA_W | Sample value |
| core_done | input | 1 | Core finished the current batch |
| dec_req | input | 1 | Core asks for the decision code segment |
| settle_cyc | input | SETTLE_W | Power settle wait, in cycles minus one |
| xfer_ack | input | 1 | Transfer engine completed the request |
| pwr_en | output | 1 | Core power switch enable |
| clk_en | output | 1 | Top-level core clock gate enable |
| xfer_req | output | 1 | State transfer request |
| xfer_op | output | 2 | 0 restore filter, 1 load decision, 2 save |
| mode | output | 2 | 0 sleep, 1 idle, 2 active |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | clog2(BATCH_LEN*NUM_SLOTS) | Buffer write address |
| buf_wdata | output | DATA_W | Buffer write data |
| run_slot | output | clog2(NUM_SLOTS) | Slot the core should consume |
| ovf_err | output | 1 | Sticky buffer overflow flag |

## Verification
The hardest situation to reach is the one where every slot is full while the core is still running. The core must be held active, with `core_done` withheld, while a complete second batch is streamed in and one more sample follows. The directed sequence first drains one batch through a full wake/save cycle, so that the write slot has moved off zero. It then wakes the core on the next batch, withholds `core_done` while the extra batch and the overflowing sample arrive, and finally releases `core_done` to observe the idle rerun instead of a power-down.

// File: rtl/batch_wake_pkg.sv
package batch_wake_pkg;
   typedef enum logic [1:0] {
      MODE_SLEEP  = 2'd0,
      MODE_IDLE   = 2'd1,
      MODE_ACTIVE = 2'd2
   } core_mode_e;

   typedef enum logic [1:0] {
      XOP_LOAD_FILT = 2'd0,
      XOP_LOAD_DEC  = 2'd1,
      XOP_SAVE      = 2'd2
   } xfer_op_e;

   typedef enum logic [2:0] {
      ST_OFF,
      ST_PWR_UP,
      ST_RESTORE,
      ST_RUN,
      ST_DEC_LOAD,
      ST_IDLE,
      ST_SAVE,
      ST_PWR_DN
   } seq_state_e;
endpackage

// File: rtl/batch_fill.sv
module batch_fill #(
   parameter int DATA_W    = 16,
   parameter int BATCH_LEN = 50,
   parameter int NUM_SLOTS = 2,
   parameter bit REG_WR    = 1'b1
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    smp_vld,
   input  logic [DATA_W-1:0]                       smp_data,
   input  logic                                    consume,
   output logic                                    buf_we,
   output logic [$clog2(BATCH_LEN*NUM_SLOTS)-1:0]  buf_addr,
   output logic [DATA_W-1:0]                       buf_wdata,
   output logic                                    have_batch,
   output logic                                    more_batch,
   output logic [$clog2(NUM_SLOTS)-1:0]            rd_slot,
   output logic                                    ovf
);
   localparam int ADDR_W = $clog2(BATCH_LEN*NUM_SLOTS);
   localparam int IDX_W  = $clog2(BATCH_LEN);
   localparam int SLOT_W = $clog2(NUM_SLOTS);
   localparam int OCC_W  = $clog2(NUM_SLOTS+1);
   localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(BATCH_LEN-1);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS-1);
   localparam logic [OCC_W-1:0]  OCC_FULL  = OCC_W'(NUM_SLOTS);
   localparam logic [ADDR_W-1:0] LEN_A     = ADDR_W'(BATCH_LEN);

   logic [IDX_W-1:0]  wr_idx;
   logic [SLOT_W-1:0] wr_slot;
   logic [OCC_W-1:0]  occ;
   logic              full, accept, last_fill;
   logic [ADDR_W-1:0] cur_addr;

   assign full      = (occ == OCC_FULL);
   assign accept    = smp_vld && !full;
   assign last_fill = accept && (wr_idx == LAST_IDX);
   assign cur_addr  = ADDR_W'(wr_slot) * LEN_A + ADDR_W'(wr_idx);

   assign have_batch = (occ != '0);
   assign more_batch = (occ > OCC_W'(1)) || ((occ == OCC_W'(1)) && last_fill);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_idx  <= '0;
         wr_slot <= '0;
         rd_slot <= '0;
         occ     <= '0;
         ovf     <= 1'b0;
      end else begin
         if (accept) begin
            if (last_fill) begin
               wr_idx  <= '0;
               wr_slot <= (wr_slot == LAST_SLOT) ? '0 : wr_slot + 1'b1;
            end else begin
               wr_idx <= wr_idx + 1'b1;
            end
         end
         if (smp_vld && full) ovf <= 1'b1;
         if (consume) rd_slot <= (rd_slot == LAST_SLOT) ? '0 : rd_slot + 1'b1;
         case ({last_fill, consume})
            2'b10:   occ <= occ + 1'b1;
            2'b01:   occ <= occ - 1'b1;
            default: occ <= occ;
         endcase
      end
   end

   generate
      if (REG_WR) begin : g_reg_wr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               buf_we    <= 1'b0;
               buf_addr  <= '0;
               buf_wdata <= '0;
            end else begin
               buf_we <= accept;
               if (accept) begin
                  buf_addr  <= cur_addr;
                  buf_wdata <= smp_data;
               end
            end
         end
         AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
            (smp_vld && full) |=> !buf_we); // R8
      end else begin : g_comb_wr
         assign buf_we    = accept;
         assign buf_addr  = cur_addr;
         assign buf_wdata = smp_data;
         AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
            (smp_vld && full) |-> !buf_we); // R8
      end
   endgenerate

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf); // R8
   AST_NO_CONSUME_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      consume |-> have_batch); // R7
endmodule

// File: rtl/batch_pwr_fsm.sv
module batch_pwr_fsm
   import batch_wake_pkg::*;
#(
   parameter int SETTLE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                have_batch,
   input  logic                more_batch,
   input  logic                core_done,
   input  logic                dec_req,
   input  logic [SETTLE_W-1:0] settle_cyc,
   input  logic                xfer_ack,
   output logic                pwr_en,
   output logic                clk_en,
   output logic                xfer_req,
   output xfer_op_e            xfer_op,
   output core_mode_e          mode,
   output logic                consume
);
   seq_state_e st, nx;
   logic [SETTLE_W-1:0] cnt;
   logic settled;

   assign settled = (cnt == settle_cyc);

   always_comb begin
      nx = st;
      case (st)
         ST_OFF:      if (have_batch) nx = ST_PWR_UP;
         ST_PWR_UP:   if (settled) nx = ST_RESTORE;
         ST_RESTORE:  if (xfer_ack) nx = ST_RUN;
         ST_RUN: begin
            if (core_done)    nx = more_batch ? ST_IDLE : ST_SAVE;
            else if (dec_req) nx = ST_DEC_LOAD;
         end
         ST_DEC_LOAD: if (xfer_ack) nx = ST_RUN;
         ST_IDLE:     nx = ST_RUN;
         ST_SAVE:     if (xfer_ack) nx = ST_PWR_DN;
         ST_PWR_DN:   if (settled) nx = ST_OFF;
         default:     nx = ST_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_OFF;
         cnt <= '0;
      end else begin
         st <= nx;
         if ((st == ST_PWR_UP || st == ST_PWR_DN) && nx == st) cnt <= cnt + 1'b1;
         else cnt <= '0;
      end
   end

   always_comb begin
      pwr_en   = (st != ST_OFF);
      clk_en   = (st == ST_RUN) || (st == ST_DEC_LOAD) || (st == ST_IDLE);
      xfer_req = (st == ST_RESTORE) || (st == ST_DEC_LOAD) || (st == ST_SAVE);
      case (st)
         ST_DEC_LOAD: xfer_op = XOP_LOAD_DEC;
         ST_SAVE:     xfer_op = XOP_SAVE;
         default:     xfer_op = XOP_LOAD_FILT;
      endcase
      case (st)
         ST_RUN, ST_DEC_LOAD: mode = MODE_ACTIVE;
         ST_IDLE:             mode = MODE_IDLE;
         default:             mode = MODE_SLEEP;
      endcase
      consume = (st == ST_RUN) && core_done;
   end

   AST_CLK_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en |-> pwr_en); // R4
   AST_CLK_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_en) |-> $past(xfer_ack)); // R4
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_op))); // R10
   AST_OFF_AFTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_en) |-> $past(!clk_en)); // R6
   AST_IDLE_RERUN: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_IDLE) |=> (mode == MODE_ACTIVE)); // R7
endmodule

// File: rtl/batch_wake_seq.sv
module batch_wake_seq
   import batch_wake_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int BATCH_LEN = 50,
   parameter int NUM_SLOTS = 2,
   parameter int SETTLE_W  = 8,
   parameter bit REG_WR    = 1'b1
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    smp_vld,
   input  logic [DATA_W-1:0]                       smp_data,
   input  logic                                    core_done,
   input  logic                                    dec_req,
   input  logic [SETTLE_W-1:0]                     settle_cyc,
   input  logic                                    xfer_ack,
   output logic                                    pwr_en,
   output logic                                    clk_en,
   output logic                                    xfer_req,
   output logic [1:0]                              xfer_op,
   output logic [1:0]                              mode,
   output logic                                    buf_we,
   output logic [$clog2(BATCH_LEN*NUM_SLOTS)-1:0]  buf_addr,
   output logic [DATA_W-1:0]                       buf_wdata,
   output logic [$clog2(NUM_SLOTS)-1:0]            run_slot,
   output logic                                    ovf_err
);
   initial begin
      assert (BATCH_LEN >= 2) else $fatal(1, "BATCH_LEN must be at least 2");
      assert (NUM_SLOTS >= 2) else $fatal(1, "NUM_SLOTS must be at least 2");
      assert (SETTLE_W >= 1)  else $fatal(1, "SETTLE_W must be at least 1");
      assert (DATA_W >= 1)    else $fatal(1, "DATA_W must be at least 1");
   end

   logic       have_batch, more_batch, consume;
   xfer_op_e   op_w;
   core_mode_e mode_w;

   batch_fill #(
      .DATA_W(DATA_W), .BATCH_LEN(BATCH_LEN),
      .NUM_SLOTS(NUM_SLOTS), .REG_WR(REG_WR)
   ) u_fill (
      .clk(clk), .rst_n(rst_n),
      .smp_vld(smp_vld), .smp_data(smp_data), .consume(consume),
      .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
      .have_batch(have_batch), .more_batch(more_batch),
      .rd_slot(run_slot), .ovf(ovf_err)
   );

   batch_pwr_fsm #(.SETTLE_W(SETTLE_W)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .have_batch(have_batch), .more_batch(more_batch),
      .core_done(core_done), .dec_req(dec_req),
      .settle_cyc(settle_cyc), .xfer_ack(xfer_ack),
      .pwr_en(pwr_en), .clk_en(clk_en), .xfer_req(xfer_req),
      .xfer_op(op_w), .mode(mode_w), .consume(consume)
   );

   assign xfer_op = op_w;
   assign mode    = mode_w;

   AST_MODE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |-> (mode == 2'd0)); // R9
endmodule

// File: tb/sim_batch_wake_seq.sv
module sim_batch_wake_seq;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;
   localparam int BLEN = 50;
   localparam int SETTLE = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_vld = 1'b0;
   logic [DW-1:0] smp_data = '0;
   logic core_done = 1'b0;
   logic dec_req = 1'b0;
   logic [7:0] settle_cyc = 8'(SETTLE);
   logic xfer_ack = 1'b0;
   logic pwr_en, clk_en, xfer_req, buf_we, ovf_err;
   logic [1:0] xfer_op, mode;
   logic [6:0] buf_addr;
   logic [DW-1:0] buf_wdata;
   logic [0:0] run_slot;

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   batch_wake_seq u0 (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
      .core_done(core_done), .dec_req(dec_req), .settle_cyc(settle_cyc),
      .xfer_ack(xfer_ack), .pwr_en(pwr_en), .clk_en(clk_en),
      .xfer_req(xfer_req), .xfer_op(xfer_op), .mode(mode),
      .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
      .run_slot(run_slot), .ovf_err(ovf_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic send(input logic [DW-1:0] d);
      smp_vld = 1'b1;
      smp_data = d;
      @(negedge clk);
      smp_vld = 1'b0;
   endtask

   task automatic ack_pulse;
      xfer_ack = 1'b1;
      @(negedge clk);
      xfer_ack = 1'b0;
   endtask

   task automatic fill_batch(input int base_addr, input int tag);
      for (int i = 0; i < BLEN; i++) begin
         send(DW'(tag + i));
         chk(buf_we == 1'b1, "R2 we", int'(buf_we), 1);
         chk(int'(buf_addr) == base_addr + i, "R2 addr", int'(buf_addr), base_addr + i);
         chk(int'(buf_wdata) == tag + i, "R2 data", int'(buf_wdata), tag + i);
      end
   endtask

   task automatic power_up;
      int n;
      int waitc;
      waitc = 0;
      while (!pwr_en && waitc < 4) begin
         @(negedge clk);
         waitc++;
      end
      chk(pwr_en == 1'b1 && waitc <= 3, "R3 wake", waitc, 3);
      n = 0;
      while (!xfer_req && n < 20) begin
         chk(clk_en == 1'b0, "R4 clock gated during settle", int'(clk_en), 0);
         n++;
         @(negedge clk);
      end
      chk(n == SETTLE + 1, "R4 settle cycles", n, SETTLE + 1);
      chk(xfer_op == 2'd0, "R4 restore op", int'(xfer_op), 0);
      chk(clk_en == 1'b0, "R4 clock gated during restore", int'(clk_en), 0);
      ack_pulse();
      chk(clk_en == 1'b1, "R4 clock after ack", int'(clk_en), 1);
      chk(mode == 2'd2, "R9 active mode", int'(mode), 2);
      chk(xfer_req == 1'b0, "R4 request cleared", int'(xfer_req), 0);
   endtask

   task automatic finish_and_sleep;
      int n;
      core_done = 1'b1;
      @(negedge clk);
      core_done = 1'b0;
      chk(clk_en == 1'b0, "R6 clock gated on done", int'(clk_en), 0);
      chk(xfer_req == 1'b1 && xfer_op == 2'd2, "R6 save op", int'(xfer_op), 2);
      chk(pwr_en == 1'b1, "R6 power held for save", int'(pwr_en), 1);
      chk(mode == 2'd0, "R9 sleep mode while gated", int'(mode), 0);
      @(negedge clk);
      chk(xfer_req == 1'b1 && xfer_op == 2'd2, "R10 save held", int'(xfer_req), 1);
      ack_pulse();
      n = 0;
      while (pwr_en && n < 20) begin
         n++;
         @(negedge clk);
      end
      chk(n == SETTLE + 1, "R6 power-off settle", n, SETTLE + 1);
      chk(mode == 2'd0 && pwr_en == 1'b0, "R6 asleep", int'(pwr_en), 0);
   endtask

   task automatic t_reset;
      chk(pwr_en == 1'b0, "R1 pwr_en", int'(pwr_en), 0);
      chk(clk_en == 1'b0, "R1 clk_en", int'(clk_en), 0);
      chk(xfer_req == 1'b0, "R1 xfer_req", int'(xfer_req), 0);
      chk(buf_we == 1'b0, "R1 buf_we", int'(buf_we), 0);
      chk(ovf_err == 1'b0, "R1 ovf_err", int'(ovf_err), 0);
      chk(mode == 2'd0, "R1 mode", int'(mode), 0);
   endtask

   task automatic t_first_batch;
      for (int i = 0; i < BLEN - 1; i++) begin
         send(DW'(16'h100 + i));
         chk(int'(buf_addr) == i && buf_wdata == DW'(16'h100 + i), "R2 first slot", int'(buf_addr), i);
      end
      repeat (3) @(negedge clk);
      chk(pwr_en == 1'b0, "R3 no wake before full batch", int'(pwr_en), 0);
      send(DW'(16'h100 + BLEN - 1));
      chk(int'(buf_addr) == BLEN - 1, "R2 last index", int'(buf_addr), BLEN - 1);
      power_up();
      chk(run_slot == 1'b0, "R7 first run slot", int'(run_slot), 0);
   endtask

   task automatic t_decision_load;
      dec_req = 1'b1;
      @(negedge clk);
      dec_req = 1'b0;
      chk(xfer_req == 1'b1 && xfer_op == 2'd1, "R5 decision op", int'(xfer_op), 1);
      chk(clk_en == 1'b1, "R5 clock kept on", int'(clk_en), 1);
      @(negedge clk);
      chk(xfer_req == 1'b1 && xfer_op == 2'd1, "R10 request held", int'(xfer_req), 1);
      ack_pulse();
      chk(mode == 2'd2 && xfer_req == 1'b0, "R5 back to active", int'(mode), 2);
   endtask

   task automatic t_pending_overflow;
      fill_batch(BLEN, 16'h200);
      power_up();
      chk(run_slot == 1'b1, "R7 run slot second batch", int'(run_slot), 1);
      fill_batch(0, 16'h300);
      chk(ovf_err == 1'b0, "R8 no overflow yet", int'(ovf_err), 0);
      send(16'hBEEF);
      chk(buf_we == 1'b0, "R8 sample dropped", int'(buf_we), 0);
      chk(ovf_err == 1'b1, "R8 overflow flagged", int'(ovf_err), 1);
      core_done = 1'b1;
      @(negedge clk);
      core_done = 1'b0;
      chk(mode == 2'd1, "R7 idle rerun", int'(mode), 1);
      chk(clk_en == 1'b1 && pwr_en == 1'b1, "R7 no power-down", int'(clk_en), 1);
      chk(run_slot == 1'b0, "R7 slot advanced", int'(run_slot), 0);
      @(negedge clk);
      chk(mode == 2'd2, "R7 active again", int'(mode), 2);
      finish_and_sleep();
      chk(ovf_err == 1'b1, "R8 overflow sticky", int'(ovf_err), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_first_batch();
      t_decision_load();
      finish_and_sleep();
      t_pending_overflow();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule